// File: doc/BRIEF.md
# Dual ring-buffer audio sample store

This block is a byte-wide, memory-mapped sample store with a small control register file, placed between a host processor and an audio playback engine. The host sees a 4 KB window. The lower 2 KB is the sample store, made of two 1 KB halves: half A feeds the left channel and half B feeds the right channel. Eight control registers sit from offset 0x800 upward.

A two-bit mode register decides how the sample store behaves. In the streaming mode (value 1), each half is an append-only ring FIFO. Host writes ignore the offset inside the buffer area, and the playback engine drains each half with a pop strobe. In every other mode (0, 2 and 3), the sample store is plain random-access byte memory.

Each control register keeps only the bits of its own write mask. The block also drives the current mode, stereo selection, volume level and rate selection straight to the playback engine.

Top module: `snd_buf`

## Requirements
- R1: After reset, every control register reads 0x00, both FIFOs are empty, and the status byte at 0x804 reads 0x05. The status byte layout is bit0 A empty, bit1 A full, bit2 B empty, bit3 B full, with all other bits 0.
- R2: Register writes keep only the bits of each register's mask: 0x801 mode 0x03, 0x802 channel control 0x83, 0x803 FIFO control 0x83, 0x805 spare 0x8F, 0x806 volume 0xFC, 0x807 rate 0x03. Bits outside the mask read back as 0. Offset 0x800 always reads 0x00, and writes to 0x800 and 0x804 are ignored.
- R3: In modes 0, 2 and 3, buffer offset 0x000–0x3FF addresses half A and offset 0x400–0x7FF addresses half B. Each offset is an independent byte that reads back what was last written to it.
- R4: In mode 1 with channel control bit1 = 0 (mono), every write anywhere in 0x000–0x7FF appends to half A in arrival order. A host read anywhere in the buffer area returns the oldest byte of A and does not remove it.
- R5: In mode 1 with channel control bit1 = 1 (stereo), writes to 0x000–0x3FF append to A and writes to 0x400–0x7FF append to B. Host buffer reads return the oldest byte of B.
- R6: Each FIFO holds 1024 bytes. An append to a full FIFO is dropped and sets channel control bit7 (overflow).
- R7: Writing FIFO control with bit7 = 1 while the stored bit7 is 0 empties both FIFOs and clears the overflow flag. The same write while the stored bit7 is already 1 leaves the FIFOs alone.
- R8: A pop on an empty FIFO has no effect. Pops have no effect outside mode 1.
- R9: play_mode_o, play_stereo_o, play_vol_o and play_rate_o follow, in that order, the mode register, channel control bit1, volume bits 7:5 and rate bits 1:0.
- R10: bus_rdata_o is registered. It carries the read result on the cycle after bus_rd_i and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Host byte offset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data, one cycle after the read |
| play_pop_a_i | input | 1 | Playback consumes one byte from A |
| play_pop_b_i | input | 1 | Playback consumes one byte from B |
| play_a_o | output | 8 | Oldest byte of A |
| play_b_o | output | 8 | Oldest byte of B |
| play_mode_o | output | 2 | Current mode |
| play_stereo_o | output | 1 | Stereo selected |
| play_vol_o | output | 3 | Volume level |
| play_rate_o | output | 2 | Rate selection |

## Verification
The bench fills a FIFO to exactly 1024 bytes and then pushes one more. A design with an off-by-one capacity would either flag the overflow too early or overwrite the oldest byte. It drains a FIFO past empty and then appends. A design that lets an empty pop move its read pointer would then present a stale byte instead of the new one. The flush is exercised both from a stored bit7 of 0 and from a stored bit7 of 1, which catches a design that flushes on level rather than on the 0-to-1 transition. Mono and stereo host reads are compared against the head of the correct half, and the mask table catches any register that keeps an unmasked bit.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FIFO = 2'd1,
    MODE_WAVE = 2'd2,
    MODE_RSV  = 2'd3
  } snd_mode_e;

  localparam logic [2:0] SEL_VER  = 3'd0;
  localparam logic [2:0] SEL_MODE = 3'd1;
  localparam logic [2:0] SEL_CHAN = 3'd2;
  localparam logic [2:0] SEL_FCTL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;
  localparam logic [2:0] SEL_AUX  = 3'd5;
  localparam logic [2:0] SEL_VOL  = 3'd6;
  localparam logic [2:0] SEL_RATE = 3'd7;

  localparam logic [7:0] MSK_MODE = 8'h03;
  localparam logic [7:0] MSK_CHAN = 8'h83;
  localparam logic [7:0] MSK_FCTL = 8'h83;
  localparam logic [7:0] MSK_AUX  = 8'h8F;
  localparam logic [7:0] MSK_VOL  = 8'hFC;
  localparam logic [7:0] MSK_RATE = 8'h03;
endpackage

// File: rtl/snd_ring.sv
module snd_ring #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ra_we_i,
  input  logic [PW-1:0] ra_addr_i,
  input  logic [DW-1:0] ra_wdata_i,
  output logic [DW-1:0] ra_rdata_o,
  input  logic          app_i,
  input  logic [DW-1:0] app_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_app, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_app  = app_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign drop_o  = app_i && full_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (ra_we_i)     mem[ra_addr_i] <= ra_wdata_i;
    else if (do_app) mem[wp_q]      <= app_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_app) wp_q <= wp_q + 1'b1;
      if (do_pop) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_app) - CW'(do_pop);
    end
  end

  assign ra_rdata_o = mem[ra_addr_i];
  assign head_o     = mem[rp_q];
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/snd_regs.sv
module snd_regs
  import snd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] wdata_i,
  input  logic       ovf_set_i,
  input  logic [7:0] status_i,
  output logic [7:0] rdata_o,
  output snd_mode_e  mode_o,
  output logic       stereo_o,
  output logic [2:0] vol_o,
  output logic [1:0] rate_o,
  output logic       flush_o,
  output logic       ovf_o
);
  logic [7:0] mode_q, chan_q, fctl_q, aux_q, vol_q, rate_q;

  // flush only on a 0 -> 1 transition of the stored bit7
  assign flush_o = we_i && (sel_i == SEL_FCTL) && wdata_i[7] && !fctl_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      chan_q <= '0;
      fctl_q <= '0;
      aux_q  <= '0;
      vol_q  <= '0;
      rate_q <= '0;
    end else begin
      if (we_i) begin
        unique case (sel_i)
          SEL_MODE: mode_q <= wdata_i & MSK_MODE;
          SEL_CHAN: chan_q <= wdata_i & MSK_CHAN;
          SEL_FCTL: fctl_q <= wdata_i & MSK_FCTL;
          SEL_AUX:  aux_q  <= wdata_i & MSK_AUX;
          SEL_VOL:  vol_q  <= wdata_i & MSK_VOL;
          SEL_RATE: rate_q <= wdata_i & MSK_RATE;
          default: ;
        endcase
      end
      if (flush_o)   chan_q[7] <= 1'b0;
      if (ovf_set_i) chan_q[7] <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_VER:  rdata_o = 8'h00;
      SEL_MODE: rdata_o = mode_q;
      SEL_CHAN: rdata_o = chan_q;
      SEL_FCTL: rdata_o = fctl_q;
      SEL_STAT: rdata_o = status_i;
      SEL_AUX:  rdata_o = aux_q;
      SEL_VOL:  rdata_o = vol_q;
      default:  rdata_o = rate_q;
    endcase
  end

  assign mode_o   = snd_mode_e'(mode_q[1:0]);
  assign stereo_o = chan_q[1];
  assign vol_o    = vol_q[7:5];
  assign rate_o   = rate_q[1:0];
  assign ovf_o    = chan_q[7];
endmodule

// File: rtl/snd_buf.sv
module snd_buf
  import snd_pkg::*;
#(
  parameter int HALF_DEPTH = 1024,
  localparam int PW = $clog2(HALF_DEPTH),
  localparam int CW = PW + 1,
  localparam int AW = PW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          play_pop_a_i,
  input  logic          play_pop_b_i,
  output logic [7:0]    play_a_o,
  output logic [7:0]    play_b_o,
  output logic [1:0]    play_mode_o,
  output logic          play_stereo_o,
  output logic [2:0]    play_vol_o,
  output logic [1:0]    play_rate_o
);
  snd_mode_e     mode;
  logic          stereo, flush, ovf_flag, fifo_m;
  logic          is_reg, reg_hit, half, wr_buf;
  logic [PW-1:0] idx;
  logic [7:0]    reg_rdata, status, rd_mux, rdata_q;
  logic [1:0]    ra_we, app, pop, full, empty, drop;
  logic [7:0]    ra_rdata [2];
  logic [7:0]    head [2];
  logic [CW-1:0] cnt [2];

  assign is_reg  = bus_addr_i[AW-1];
  assign reg_hit = is_reg && (bus_addr_i[AW-2:3] == '0);
  assign half    = bus_addr_i[AW-2];
  assign idx     = bus_addr_i[PW-1:0];
  assign fifo_m  = (mode == MODE_FIFO);
  assign wr_buf  = bus_wr_i && !is_reg;

  assign ra_we[0] = wr_buf && !fifo_m && !half;
  assign ra_we[1] = wr_buf && !fifo_m &&  half;
  assign app[0]   = wr_buf && fifo_m && (!stereo || !half);
  assign app[1]   = wr_buf && fifo_m && stereo && half;
  assign pop[0]   = play_pop_a_i && fifo_m;
  assign pop[1]   = play_pop_b_i && fifo_m;

  for (genvar h = 0; h < 2; h++) begin : g_half
    snd_ring #(.DEPTH(HALF_DEPTH), .DW(BYTE_W)) u_ring (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ra_we_i    (ra_we[h]),
      .ra_addr_i  (idx),
      .ra_wdata_i (bus_wdata_i),
      .ra_rdata_o (ra_rdata[h]),
      .app_i      (app[h]),
      .app_data_i (bus_wdata_i),
      .pop_i      (pop[h]),
      .flush_i    (flush),
      .head_o     (head[h]),
      .cnt_o      (cnt[h]),
      .full_o     (full[h]),
      .empty_o    (empty[h]),
      .drop_o     (drop[h])
    );
  end

  assign status = {4'b0, full[1], empty[1], full[0], empty[0]};

  snd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_wr_i && reg_hit),
    .sel_i     (bus_addr_i[2:0]),
    .wdata_i   (bus_wdata_i),
    .ovf_set_i (|drop),
    .status_i  (status),
    .rdata_o   (reg_rdata),
    .mode_o    (mode),
    .stereo_o  (stereo),
    .vol_o     (play_vol_o),
    .rate_o    (play_rate_o),
    .flush_o   (flush),
    .ovf_o     (ovf_flag)
  );

  always_comb begin
    if (is_reg)      rd_mux = reg_hit ? reg_rdata : 8'h00;
    else if (fifo_m) rd_mux = stereo ? head[1] : head[0];
    else             rd_mux = ra_rdata[half];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o   = rdata_q;
  assign play_a_o      = head[0];
  assign play_b_o      = head[1];
  assign play_mode_o   = mode;
  assign play_stereo_o = stereo;
endmodule

// File: rtl/snd_buf_chk.sv
module snd_buf_chk #(
  parameter int HALF_DEPTH = 1024,
  localparam int CW = $clog2(HALF_DEPTH) + 1,
  localparam int AW = CW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_rd_i,
  input logic [7:0]    bus_rdata_o,
  input logic [1:0]    app,
  input logic [1:0]    pop,
  input logic          flush,
  input logic          ovf_flag,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b
);
  assert_ver_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == AW'(2*HALF_DEPTH) |=> bus_rdata_o == 8'h00);

  assert_vol_low_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == AW'(2*HALF_DEPTH + 6) |=> bus_rdata_o[1:0] == 2'b00);

  assert_cap_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a <= CW'(HALF_DEPTH) && cnt_b <= CW'(HALF_DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a == CW'(HALF_DEPTH) && app[0] && !pop[0] && !flush |=> $stable(cnt_a) && ovf_flag);

  assert_flush_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> cnt_a == '0 && cnt_b == '0 && !ovf_flag);

  assert_empty_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a == '0 && pop[0] && !app[0] |=> cnt_a == '0);

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind snd_buf snd_buf_chk #(.HALF_DEPTH(HALF_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .app         (app),
  .pop         (pop),
  .flush       (flush),
  .ovf_flag    (ovf_flag),
  .cnt_a       (cnt[0]),
  .cnt_b       (cnt[1])
);

// File: tb/snd_buf_test.sv
module snd_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        pop_a = 1'b0, pop_b = 1'b0;
  logic [7:0]  pa, pb;
  logic [1:0]  pmode, prate;
  logic        pster;
  logic [2:0]  pvol;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  got;

  always #10 clk = ~clk;

  snd_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .play_pop_a_i(pop_a), .play_pop_b_i(pop_b),
    .play_a_o(pa), .play_b_o(pb), .play_mode_o(pmode), .play_stereo_o(pster),
    .play_vol_o(pvol), .play_rate_o(prate)
  );

  // {addr, wdata, expected readback}
  localparam logic [27:0] VEC [12] = '{
    {12'h801, 8'hFF, 8'h03}, {12'h801, 8'h06, 8'h02}, {12'h802, 8'hFF, 8'h83},
    {12'h802, 8'h7C, 8'h00}, {12'h803, 8'hFF, 8'h83}, {12'h805, 8'hFF, 8'h8F},
    {12'h805, 8'h70, 8'h00}, {12'h806, 8'hFF, 8'hFC}, {12'h806, 8'h13, 8'h10},
    {12'h807, 8'hFF, 8'h03}, {12'h800, 8'hFF, 8'h00}, {12'h804, 8'hFF, 8'h05}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pop_x(input logic a, input logic b);
    @(negedge clk); pop_a = a; pop_b = b;
    @(negedge clk); pop_a = 1'b0; pop_b = 1'b0;
  endtask

  task automatic flush_all();
    wr_b(12'h803, 8'h00);
    wr_b(12'h803, 8'h80);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd_b(12'h800 + 12'(r), got);
      chk("R1 reset reg", got, (r == 4) ? 8'h05 : 8'h00);
    end
    chk("R1 play outputs", {pmode, pster, pvol, prate}, 8'h00);

    // R2 mask table
    for (int i = 0; i < 12; i++) begin
      wr_b(VEC[i][27:16], VEC[i][15:8]);
      rd_b(VEC[i][27:16], got);
      chk("R2 mask", got, VEC[i][7:0]);
    end
    wr_b(12'h802, 8'h00); wr_b(12'h803, 8'h00);

    // R9 outputs to playback
    wr_b(12'h806, 8'hA0); wr_b(12'h807, 8'h02); wr_b(12'h801, 8'h01); wr_b(12'h802, 8'h02);
    chk("R9 vol", {5'b0, pvol}, 8'h05);
    chk("R9 rate", {6'b0, prate}, 8'h02);
    chk("R9 mode", {6'b0, pmode}, 8'h01);
    chk("R9 stereo", {7'b0, pster}, 8'h01);
    wr_b(12'h802, 8'h00);

    // R3 random access in modes 0, 2, 3
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        wr_b(12'h801, 8'(m));
        wr_b(12'h010 + 12'(m), 8'h30 + 8'(m));
        wr_b(12'h410 + 12'(m), 8'h60 + 8'(m));
        rd_b(12'h010 + 12'(m), got); chk("R3 half A", got, 8'h30 + 8'(m));
        rd_b(12'h410 + 12'(m), got); chk("R3 half B", got, 8'h60 + 8'(m));
      end
    end
    rd_b(12'h012, got); chk("R3 offset kept", got, 8'h32);

    // R4 mono append
    wr_b(12'h801, 8'h01); flush_all(); wr_b(12'h803, 8'h00);
    wr_b(12'h123, 8'hA1); wr_b(12'h555, 8'hA2);
    rd_b(12'h7F0, got); chk("R4 mono read head A", got, 8'hA1);
    chk("R4 play A", pa, 8'hA1);
    rd_b(12'h804, got); chk("R4 status", got, 8'h04);
    pop_x(1'b1, 1'b0);
    chk("R4 second byte", pa, 8'hA2);

    // R8 empty pops, pops outside mode 1
    pop_x(1'b1, 1'b0);
    rd_b(12'h804, got); chk("R8 A empty", got, 8'h05);
    pop_x(1'b1, 1'b1);
    wr_b(12'h3FF, 8'hD0);
    chk("R8 head after empty pop", pa, 8'hD0);
    wr_b(12'h801, 8'h00); pop_x(1'b1, 1'b0); wr_b(12'h801, 8'h01);
    chk("R8 pop in mode 0", pa, 8'hD0);
    rd_b(12'h804, got); chk("R8 status kept", got, 8'h04);

    // R5 stereo
    flush_all(); wr_b(12'h803, 8'h00);
    wr_b(12'h802, 8'h02);
    wr_b(12'h001, 8'hB1); wr_b(12'h401, 8'hC1); wr_b(12'h7FF, 8'hC2);
    rd_b(12'h000, got); chk("R5 stereo read head B", got, 8'hC1);
    chk("R5 play A", pa, 8'hB1);
    chk("R5 play B", pb, 8'hC1);
    pop_x(1'b0, 1'b1);
    chk("R5 B second", pb, 8'hC2);
    chk("R5 A untouched", pa, 8'hB1);

    // R6 capacity and overflow
    wr_b(12'h802, 8'h00); flush_all();
    for (int i = 0; i < 1024; i++) wr_b(12'(i), 8'(i));
    rd_b(12'h804, got); chk("R6 A full", got, 8'h06);
    rd_b(12'h802, got); chk("R6 no overflow yet", got, 8'h00);
    wr_b(12'h000, 8'hEE);
    rd_b(12'h802, got); chk("R6 overflow flag", got, 8'h80);
    chk("R6 oldest kept", pa, 8'h00);
    pop_x(1'b1, 1'b0);
    chk("R6 next byte", pa, 8'h01);

    // R7 flush edge
    wr_b(12'h803, 8'h00); wr_b(12'h803, 8'h80);
    rd_b(12'h804, got); chk("R7 flushed", got, 8'h05);
    rd_b(12'h802, got); chk("R7 overflow cleared", got, 8'h00);
    wr_b(12'h200, 8'h5A);
    wr_b(12'h803, 8'h80);
    rd_b(12'h804, got); chk("R7 no flush at stored 1", got, 8'h04);
    chk("R7 data kept", pa, 8'h5A);

    // R10 read data holds
    rd_b(12'h807, got);
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule